// File: doc/BRIEF.md
# Two-Wire Bus Master Command Sequencer

This block is the sequencing layer of a two-wire serial bus master. It turns single-cycle command strobes (begin, end, enable, disable, soft reset) and a stream of bytes to transmit into a series of operations for a separate bit-level engine. Each operation is START (which covers the address phase), WRITE a byte, READ a byte, or STOP. The engine does all line timing. This block only decides which operation comes next, based on the engine's completion and acknowledge reports.

In write mode a frame opens as soon as a byte lands in the one-entry holding register. Bytes keep flowing while the holding register is refilled in time. STOP follows on its own once the engine has finished a byte and nothing is held. In read mode a begin strobe opens the frame, and bytes are read until an end request (or a disable) makes the byte in progress the last one. The master answers that last byte with NACK and then issues STOP. A slave NACK on the address or on a written byte ends the frame at once. Disable takes priority over enable and lets the current frame finish its pending work.

The transmit side is valid/ready: `tx_ready` is high exactly while the holding register is empty, and a byte moves on a cycle with both high. The engine request is also valid/ready: `eng_req` with its command and data holds steady until `eng_ready`. Received bytes leave as a one-cycle `rx_valid` pulse with no back-pressure, so the consumer must take every pulse.

Top module: `twm_cmd_ctrl`

## Requirements
- R1: After `rst_n` low or a `cmd_srst` strobe: `busy`=0, `enabled`=0, `tx_ready`=1, `eng_req`=0, with no frame pending.
- R2: `eng_cmd` encodes START=0, WRITE=1, READ=2, STOP=3. Once `eng_req` rises, it and `eng_cmd`/`eng_wdata` hold until `eng_ready`. No new request is raised before `eng_done` of the previous one.
- R3: In write mode (`cfg_read`=0) with `enabled`=1, a byte in the holding register starts a frame: START, then WRITE of that byte. A write frame never issues READ.
- R4: In a write frame, when a WRITE completes and the holding register is empty, STOP is the next operation. Bytes refilled in time are all sent in order.
- R5: In read mode, a `cmd_start` strobe while enabled and idle starts a frame: START, then READ operations.
- R6: `cmd_start` and `cmd_stop` in the same cycle in read mode give START, one READ with `eng_mnack`=1, then STOP.
- R7: In a read frame, `eng_mnack` is 0 on every READ except the one that completes while an end request is pending. That READ carries 1 and is followed by STOP.
- R8: `eng_nack`=1 on completion of START or WRITE makes STOP the next operation. In a write frame the held byte is discarded (`tx_ready` returns to 1).
- R9: `cmd_dis` clears `enabled` and wins over `cmd_en` in the same cycle. `cmd_en` alone sets `enabled`.
- R10: Disabling during a write frame still sends the shifting and held bytes, then STOP. While disabled, a held byte starts no frame.
- R11: Disabling during a read frame lets the READ in progress complete with `eng_mnack`=1, then STOP.
- R12: Each completed READ gives one `rx_valid` pulse, the cycle after `eng_done`, carrying `eng_rdata`. A held byte stays unchanged until taken by a WRITE.
- R13: `frame_done` pulses once per frame, the cycle after the STOP completes, and `busy` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | Begin-frame strobe |
| cmd_stop | input | 1 | End-of-read request strobe |
| cmd_en | input | 1 | Enable-master strobe |
| cmd_dis | input | 1 | Disable-master strobe |
| cmd_srst | input | 1 | Soft reset strobe |
| cfg_read | input | 1 | Direction: 1 read, 0 write |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| eng_req | output | 1 | Operation request to bit engine |
| eng_ready | input | 1 | Engine accepts request |
| eng_cmd | output | 2 | Operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_mnack | output | 1 | Master answers NACK to this read byte |
| eng_done | input | 1 | Operation complete |
| eng_nack | input | 1 | Slave answered NACK |
| eng_rdata | input | 8 | Byte read |
| busy | output | 1 | Frame in progress |
| enabled | output | 1 | Master enabled flag |
| frame_done | output | 1 | Frame finished pulse |

## Verification
On every cycle the assertions check the request hold rule toward the engine, that no READ appears in a write frame, and that STOP follows a slave NACK or a master-NACKed read. They also check that a held byte is kept stable, that `rx_valid` never lasts two cycles, and the enable/disable priority. Whole operation sequences can only be shown by the bench's scenarios. These include the order and content of bytes written, the draining of the holding register on disable, the position of the master NACK in multi-byte reads, the discarding of a held byte after NACK, and the soft reset in mid-frame. The bench checks each of these against logs from its engine model.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/twm_hold.sv
module twm_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic          full,
  output logic [DW-1:0] data
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (clr) begin
      full <= 1'b0;
    end else begin
      if (pop) full <= 1'b0;
      if (in_valid && in_ready) begin
        full <= 1'b1;
        data <= in_data;
      end
    end
  end

  // R12: only a held byte may be taken
  assert_pop_has_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full);
  // R12: a held byte stays put until taken or flushed
  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (full && !pop) |=> (full && $stable(data)));
endmodule

// File: rtl/twm_flags.sv
module twm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic cfg_read,
  input  logic busy,
  input  logic frame_rd,
  input  logic start_issue,
  input  logic stop_issue,
  output logic enabled,
  output logic start_pend,
  output logic stop_pend
);
  logic stop_take;
  assign stop_take = cmd_stop && (busy ? frame_rd : (cfg_read && cmd_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled    <= 1'b0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else if (clr) begin
      enabled    <= 1'b0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      if (cmd_dis)     enabled <= 1'b0;
      else if (cmd_en) enabled <= 1'b1;

      if (start_issue)                          start_pend <= 1'b0;
      else if (cmd_start && enabled && !busy)   start_pend <= 1'b1;

      if (stop_issue)     stop_pend <= 1'b0;
      else if (stop_take) stop_pend <= 1'b1;
    end
  end

  assert_disable_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dis && !clr) |=> !enabled);
  assert_enable_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_dis && !clr) |=> enabled);
endmodule

// File: rtl/twm_seq.sv
module twm_seq
  import twm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          enabled,
  input  logic          start_pend,
  input  logic          stop_pend,
  input  logic          cfg_read,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          hold_pop,
  output logic          hold_flush,
  output logic          eng_req,
  input  logic          eng_ready,
  output logic [1:0]    eng_cmd,
  output logic [DW-1:0] eng_wdata,
  output logic          eng_mnack,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [DW-1:0] eng_rdata,
  output logic          start_issue,
  output logic          stop_issue,
  output logic          busy,
  output logic          frame_rd,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          frame_done
);
  seq_st_e st;
  bus_op_e op, nxt;
  logic accept, fin, launch, finish_rd;

  always_comb begin
    accept      = (st == SQ_REQ) && eng_ready;
    fin         = (st == SQ_WAIT) && eng_done;
    launch      = (st == SQ_IDLE) && enabled && (start_pend || (!cfg_read && hold_full));
    finish_rd   = stop_pend || !enabled;
    eng_req     = (st == SQ_REQ);
    eng_cmd     = op;
    eng_wdata   = (op == OP_WRITE) ? hold_data : '0;
    eng_mnack   = frame_rd && finish_rd;
    hold_pop    = accept && (op == OP_WRITE);
    start_issue = accept && (op == OP_START);
    stop_issue  = accept && (op == OP_STOP);
    hold_flush  = fin && eng_nack && !frame_rd && (op != OP_STOP);
    busy        = (st != SQ_IDLE);
    if (op != OP_READ && eng_nack)  nxt = OP_STOP;
    else if (frame_rd)              nxt = (op == OP_READ && finish_rd) ? OP_STOP : OP_READ;
    else                            nxt = hold_full ? OP_WRITE : OP_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; op <= OP_START; frame_rd <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; frame_done <= 1'b0;
    end else if (clr) begin
      st <= SQ_IDLE; op <= OP_START; frame_rd <= 1'b0;
      rx_valid <= 1'b0; frame_done <= 1'b0;
    end else begin
      rx_valid   <= fin && (op == OP_READ);
      frame_done <= fin && (op == OP_STOP);
      if (fin && op == OP_READ) rx_data <= eng_rdata;
      case (st)
        SQ_IDLE: if (launch) begin
          op <= OP_START; frame_rd <= cfg_read; st <= SQ_REQ;
        end
        SQ_REQ:  if (eng_ready) st <= SQ_WAIT;
        SQ_WAIT: if (eng_done) begin
          if (op == OP_STOP) st <= SQ_IDLE;
          else begin op <= nxt; st <= SQ_REQ; end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (eng_req && !eng_ready) |=> (eng_req && $stable(eng_cmd) && $stable(eng_wdata)));
  assert_no_read_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (eng_req && !frame_rd) |-> (eng_cmd != OP_READ));
  assert_nack_stops_R8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (fin && eng_nack && (op == OP_START || op == OP_WRITE)) |=> (eng_req && eng_cmd == OP_STOP));
  assert_nacked_read_last_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (fin && op == OP_READ && eng_mnack) |=> (eng_req && eng_cmd == OP_STOP));
  assert_write_drain_R10: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (fin && !frame_rd && op == OP_WRITE && !eng_nack && hold_full) |=> (eng_cmd == OP_WRITE));
  assert_rx_single_R12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/twm_cmd_ctrl.sv
module twm_cmd_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_srst,
  input  logic              cfg_read,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              eng_req,
  input  logic              eng_ready,
  output logic [1:0]        eng_cmd,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              eng_mnack,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              busy,
  output logic              enabled,
  output logic              frame_done
);
  logic hold_full, hold_pop, hold_flush, hold_clr;
  logic [DATA_W-1:0] hold_data;
  logic start_pend, stop_pend, start_issue, stop_issue, frame_rd;

  assign hold_clr = cmd_srst || hold_flush;

  twm_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .pop(hold_pop), .full(hold_full), .data(hold_data)
  );

  twm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(cmd_srst),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
    .cfg_read(cfg_read), .busy(busy), .frame_rd(frame_rd),
    .start_issue(start_issue), .stop_issue(stop_issue),
    .enabled(enabled), .start_pend(start_pend), .stop_pend(stop_pend)
  );

  twm_seq #(.DW(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(cmd_srst),
    .enabled(enabled), .start_pend(start_pend), .stop_pend(stop_pend),
    .cfg_read(cfg_read), .hold_full(hold_full), .hold_data(hold_data),
    .hold_pop(hold_pop), .hold_flush(hold_flush),
    .eng_req(eng_req), .eng_ready(eng_ready), .eng_cmd(eng_cmd),
    .eng_wdata(eng_wdata), .eng_mnack(eng_mnack), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_rdata(eng_rdata),
    .start_issue(start_issue), .stop_issue(stop_issue),
    .busy(busy), .frame_rd(frame_rd),
    .rx_valid(rx_valid), .rx_data(rx_data), .frame_done(frame_done)
  );
endmodule

// File: tb/tb_twm_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_twm_cmd_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_start, cmd_stop, cmd_en, cmd_dis, cmd_srst, cfg_read;
  logic tx_valid, tx_ready, rx_valid, eng_req, eng_ready, eng_mnack, eng_done, eng_nack;
  logic busy, enabled, frame_done;
  logic [7:0] tx_data, rx_data, eng_wdata, eng_rdata;
  logic [1:0] eng_cmd;

  twm_cmd_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [1:0] lg_cmd [0:63];
  logic [7:0] lg_dat [0:63];
  logic       lg_mack[0:63];
  logic [7:0] rx_log [0:63];
  int lg_n = 0, rx_n = 0, fd_n = 0, nack_at = -1, r2_err = 0;
  bit r2_off = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_cmd(input bit rd, input int k, input int n);
    if (k == 0) return 0;
    if (k == n + 1) return 3;
    return rd ? 2 : 1;
  endfunction

  function automatic int exp_mack(input int i, input int n);
    return (i == n - 1) ? 1 : 0;
  endfunction

  // bit-engine model: grants, delays, completes; logs every accepted operation
  initial begin
    int dly, cur;
    bit busy_m, pend, pv;
    logic [1:0] pc; logic [7:0] pd;
    eng_ready = 0; eng_done = 0; eng_nack = 0; eng_rdata = 0;
    busy_m = 0; pend = 0; dly = 0; cur = 0; pc = 0; pd = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_nack = 0;
      if (!rst_n) begin
        busy_m = 0; eng_ready = 0; pend = 0;
      end else begin
        pv = (eng_req === 1'b1);
        if (!r2_off && pend && !(pv && eng_cmd == pc && eng_wdata == pd)) r2_err++;
        if (!r2_off && busy_m && pv) r2_err++;
        pend = 0;
        if (eng_ready) begin
          eng_ready = 0; busy_m = 1; dly = 3 + int'($urandom % 3);
        end else if (busy_m) begin
          if (dly == 0) begin
            busy_m = 0; eng_done = 1;
            if (lg_cmd[cur] == 2'd2) begin
              eng_rdata = 8'($urandom);
              lg_dat[cur] = eng_rdata;
              lg_mack[cur] = eng_mnack;
            end else eng_nack = (cur == nack_at);
          end else dly--;
        end else if (pv) begin
          if ($urandom % 2 == 0) begin
            eng_ready = 1; cur = lg_n;
            lg_cmd[lg_n] = eng_cmd; lg_dat[lg_n] = eng_wdata; lg_mack[lg_n] = 0;
            if (lg_n < 63) lg_n++;
          end else begin
            pend = 1; pc = eng_cmd; pd = eng_wdata;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid === 1'b1 && rx_n < 64) begin rx_log[rx_n] = rx_data; rx_n++; end
      if (frame_done === 1'b1) fd_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic clr_log();
    lg_n = 0; rx_n = 0; fd_n = 0; nack_at = -1;
  endtask

  task automatic strobe(input bit s, input bit p, input bit e, input bit d, input bit r);
    @(negedge clk);
    cmd_start = s; cmd_stop = p; cmd_en = e; cmd_dis = d; cmd_srst = r;
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cmd_en = 0; cmd_dis = 0; cmd_srst = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1; tx_data = d;
    while (tx_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_fd();
    while (fd_n < 1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic hard_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic do_write(input int n);
    logic [7:0] d [0:7];
    clr_log(); cfg_read = 0;
    for (int i = 0; i < n; i++) d[i] = 8'($urandom);
    for (int i = 0; i < n; i++) push(d[i]);
    wait_fd();
    chk("R4", "write op count", lg_n, n + 2);
    for (int k = 0; k < n + 2; k++) chk("R3", "write op code", int'(lg_cmd[k]), exp_cmd(0, k, n));
    for (int i = 0; i < n; i++) chk("R4", "write byte order", int'(lg_dat[i + 1]), int'(d[i]));
    chk("R13", "one frame_done", fd_n, 1);
    chk("R13", "busy after frame", int'(busy), 0);
  endtask

  task automatic do_read(input int n);
    clr_log(); cfg_read = 1;
    if (n == 1) strobe(1, 1, 0, 0, 0);
    else begin
      strobe(1, 0, 0, 0, 0);
      while (rx_n < n - 1) @(negedge clk);
      strobe(0, 1, 0, 0, 0);
    end
    wait_fd();
    chk("R5", "read op count", lg_n, n + 2);
    for (int k = 0; k < n + 2; k++) chk("R5", "read op code", int'(lg_cmd[k]), exp_cmd(1, k, n));
    for (int i = 0; i < n; i++) begin
      if (n == 1) chk("R6", "single read mnack", int'(lg_mack[1]), 1);
      else chk("R7", "read mnack position", int'(lg_mack[i + 1]), exp_mack(i, n));
    end
    chk("R12", "rx pulse count", rx_n, n);
    for (int i = 0; i < n; i++) chk("R12", "rx byte", int'(rx_log[i]), int'(lg_dat[i + 1]));
    chk("R13", "one frame_done", fd_n, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cmd_start = 0; cmd_stop = 0; cmd_en = 0; cmd_dis = 0; cmd_srst = 0;
    cfg_read = 0; tx_valid = 0; tx_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "enabled after reset", int'(enabled), 0);
    chk("R1", "tx_ready after reset", int'(tx_ready), 1);
    chk("R1", "eng_req after reset", int'(eng_req), 0);

    // held byte while disabled starts nothing; en+dis together stays disabled
    clr_log(); cfg_read = 0;
    push(8'h5A);
    repeat (20) @(negedge clk);
    chk("R10", "no frame while disabled", int'(busy), 0);
    chk("R12", "byte held while disabled", int'(tx_ready), 0);
    strobe(0, 0, 1, 1, 0);
    chk("R9", "disable wins over enable", int'(enabled), 0);
    repeat (5) @(negedge clk);
    chk("R9", "no frame after en+dis", lg_n, 0);
    strobe(0, 0, 1, 0, 0);
    chk("R9", "enable sets flag", int'(enabled), 1);
    wait_fd();
    chk("R3", "held byte frame length", lg_n, 3);
    chk("R3", "first op START", int'(lg_cmd[0]), 0);
    chk("R3", "held byte sent", int'(lg_dat[1]), 8'h5A);
    chk("R4", "auto STOP", int'(lg_cmd[2]), 3);

    // directed read corners
    do_read(1);
    do_read(4);

    // random mix of frames
    for (int f = 0; f < 16; f++) begin
      if ($urandom % 2) do_read(1 + int'($urandom % 5));
      else do_write(1 + int'($urandom % 5));
    end

    // slave NACK on address of a read
    clr_log(); cfg_read = 1; nack_at = 0;
    strobe(1, 0, 0, 0, 0);
    wait_fd();
    chk("R8", "read addr nack op count", lg_n, 2);
    chk("R8", "STOP after addr nack", int'(lg_cmd[1]), 3);
    chk("R8", "no byte received", rx_n, 0);

    // slave NACK on first written byte: held byte dropped
    clr_log(); cfg_read = 0; nack_at = 1;
    push(8'h11); push(8'h22);
    wait_fd();
    repeat (10) @(negedge clk);
    chk("R8", "write nack op count", lg_n, 3);
    chk("R8", "STOP after write nack", int'(lg_cmd[2]), 3);
    chk("R8", "held byte discarded", int'(tx_ready), 1);
    chk("R8", "no new frame", int'(busy), 0);

    // disable during write drains both bytes
    clr_log(); cfg_read = 0;
    push(8'hC1); push(8'hC2);
    strobe(0, 0, 0, 1, 0);
    wait_fd();
    chk("R10", "drain op count", lg_n, 4);
    chk("R10", "drain byte 0", int'(lg_dat[1]), 8'hC1);
    chk("R10", "drain byte 1", int'(lg_dat[2]), 8'hC2);
    chk("R10", "drain STOP", int'(lg_cmd[3]), 3);
    chk("R10", "disabled after drain", int'(enabled), 0);
    clr_log();
    push(8'hC3);
    repeat (20) @(negedge clk);
    chk("R10", "no launch while disabled", lg_n, 0);
    strobe(0, 0, 1, 0, 0);
    wait_fd();
    chk("R10", "launch after re-enable", int'(lg_dat[1]), 8'hC3);

    // disable during read
    clr_log(); cfg_read = 1;
    strobe(1, 0, 0, 0, 0);
    while (rx_n < 1) @(negedge clk);
    strobe(0, 0, 0, 1, 0);
    wait_fd();
    chk("R11", "read drain op count", lg_n, 4);
    chk("R11", "first read acked", int'(lg_mack[1]), 0);
    chk("R11", "last read nacked", int'(lg_mack[2]), 1);
    chk("R11", "STOP after drain", int'(lg_cmd[3]), 3);
    chk("R11", "bytes received", rx_n, 2);
    strobe(0, 0, 1, 0, 0);

    // soft reset mid-frame
    clr_log(); cfg_read = 1;
    strobe(1, 0, 0, 0, 0);
    while (rx_n < 1) @(negedge clk);
    r2_off = 1;
    strobe(0, 0, 0, 0, 1);
    chk("R1", "busy after soft reset", int'(busy), 0);
    chk("R1", "enabled after soft reset", int'(enabled), 0);
    chk("R1", "tx_ready after soft reset", int'(tx_ready), 1);
    chk("R1", "eng_req after soft reset", int'(eng_req), 0);
    repeat (10) @(negedge clk);
    hard_reset();
    r2_off = 0;

    chk("R2", "engine handshake violations", r2_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule